// File: doc/BRIEF.md
# Bouncing LED Scanner with Faded Trail

This block lights a row of LEDs as a single bright spot that sweeps from one end of the row to the other and back, over and over. The moving spot is driven fully on. The three LEDs it has just passed stay partly lit at falling brightness, so the spot seems to leave a fading tail behind it. Brightness comes from pulse-width modulation. One free-running phase counter with a 100-tick period is shared by every LED, and each LED compares that phase with its own duty value.

A prescaler turns the system clock into step events, one every `STEP_TICKS` cycles. On each step the spot moves by exactly one position. At an end of the row it turns around without lighting that end twice and without skipping it. The tail is always on the side the spot has just come from, and it is cut off where it would run past the end of the row. The LED outputs are registered, so they follow the internal state one clock later. The only inputs are the clock and a synchronous active-high reset.

Top module: `led_scanner`

## Requirements
- R1: While reset is asserted, and in the first cycle after an edge that samples reset high, every LED output is 0. After reset is released the spot starts at LED 0 and moves toward higher indices.
- R2: The LED at the spot position is on for 100 of every 100 consecutive clock cycles.
- R3: The LED one position behind the spot, on the side it came from, is on for 50 of every 100 consecutive cycles.
- R4: The LED two positions behind the spot is on for 20 of every 100 consecutive cycles.
- R5: The LED three positions behind the spot is on for 10 of every 100 consecutive cycles.
- R6: Every other LED is off for the whole step. This includes the LEDs ahead of the spot and any tail position that falls outside the row, so at most four LEDs are ever lit.
- R7: The spot position changes only on a step event, which occurs once every `STEP_TICKS` clock cycles, and it then moves by exactly one position.
- R8: When the spot reaches LED `NUM_LEDS-1` it next moves to `NUM_LEDS-2`. When it reaches LED 0 it next moves to LED 1. The sweep therefore repeats with a period of `2*NUM_LEDS-2` steps, and right after a turn the tail lies beyond the spot, toward the end it has just left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| led | output | NUM_LEDS | One PWM on/off drive per LED, registered |

## Verification
The bench builds the scanner with `NUM_LEDS=5` and `STEP_TICKS=200`. A five-LED row turns around every four steps, so twenty steps cover several turns at both ends and show the tail being clipped at each end. A 200-cycle step leaves room to count exactly 100 consecutive cycles inside every step. That window gives the exact duty of each LED and allows no slack. A second reset in the middle of a sweep confirms that the start position and the direction of travel are restored.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int unsigned PWM_PERIOD = 100;
    localparam int unsigned DUTY_W     = $clog2(PWM_PERIOD + 1);
    localparam int unsigned TAIL_LEN   = 3;

    typedef logic [DUTY_W-1:0] duty_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Brightness for an LED at a given distance behind the spot (0 = spot).
    function automatic duty_t level_for_gap(input int gap);
        duty_t lvl;
        case (gap)
            0:       lvl = duty_t'(100);
            1:       lvl = duty_t'(50);
            2:       lvl = duty_t'(20);
            3:       lvl = duty_t'(10);
            default: lvl = '0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/led_scan_prescaler.sv
module led_scan_prescaler #(
    parameter int unsigned STEP_TICKS = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic step
);
    localparam int unsigned CNT_W = (STEP_TICKS > 2) ? $clog2(STEP_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = (st_q.cnt == LAST);
        if (step) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/led_scan_pwm.sv
module led_scan_pwm
    import led_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output duty_t phase
);
    localparam duty_t PHASE_LAST = duty_t'(PWM_PERIOD - 1);

    typedef struct packed {
        duty_t ph;
    } pwm_state_t;

    pwm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PHASE_LAST) begin
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        phase = st_q.ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/led_scan_sweep.sv
module led_scan_sweep
    import led_scan_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 8,
    localparam int unsigned POS_W   = (NUM_LEDS > 2) ? $clog2(NUM_LEDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output dir_e             dir
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_LEDS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        dir_e             dir;
    } sweep_state_t;

    sweep_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.dir == DIR_UP) begin
                if (st_q.pos == POS_LAST) begin
                    st_d.pos = st_q.pos - 1'b1;
                    st_d.dir = DIR_DOWN;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end else begin
                if (st_q.pos == '0) begin
                    st_d.pos = st_q.pos + 1'b1;
                    st_d.dir = DIR_UP;
                end else begin
                    st_d.pos = st_q.pos - 1'b1;
                end
            end
        end
        pos = st_q.pos;
        dir = st_q.dir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos <= '0;
            st_q.dir <= DIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/led_scan_shade.sv
module led_scan_shade
    import led_scan_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 8,
    localparam int unsigned POS_W   = (NUM_LEDS > 2) ? $clog2(NUM_LEDS) : 1
) (
    input  logic [POS_W-1:0]    pos,
    input  dir_e                dir,
    input  duty_t               phase,
    output logic [NUM_LEDS-1:0] lit
);
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        duty_t lvl;
        always_comb begin
            lvl = '0;
            if (dir == DIR_UP) begin
                // tail sits below the spot
                if (i <= int'(pos)) begin
                    lvl = level_for_gap(int'(pos) - i);
                end
            end else begin
                // tail sits above the spot
                if (i >= int'(pos)) begin
                    lvl = level_for_gap(i - int'(pos));
                end
            end
            lit[i] = (phase < lvl);
        end
    end

endmodule

// File: rtl/led_scanner.sv
module led_scanner
    import led_scan_pkg::*;
#(
    parameter int unsigned NUM_LEDS   = 8,
    parameter int unsigned STEP_TICKS = 50000
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_LEDS-1:0] led
);
    localparam int unsigned POS_W = (NUM_LEDS > 2) ? $clog2(NUM_LEDS) : 1;

    typedef struct packed {
        logic [NUM_LEDS-1:0] led;
    } out_state_t;

    logic                step_pulse;
    logic [POS_W-1:0]    head_pos;
    dir_e                head_dir;
    duty_t               pwm_phase;
    logic [NUM_LEDS-1:0] lit_w;
    out_state_t          st_d, st_q;

    led_scan_prescaler #(
        .STEP_TICKS (STEP_TICKS)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .step (step_pulse)
    );

    led_scan_pwm u_pwm (
        .clk   (clk),
        .rst   (rst),
        .phase (pwm_phase)
    );

    led_scan_sweep #(
        .NUM_LEDS (NUM_LEDS)
    ) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .step (step_pulse),
        .pos  (head_pos),
        .dir  (head_dir)
    );

    led_scan_shade #(
        .NUM_LEDS (NUM_LEDS)
    ) u_shade (
        .pos   (head_pos),
        .dir   (head_dir),
        .phase (pwm_phase),
        .lit   (lit_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.led = lit_w;
        led      = st_q.led;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/led_scanner_chk.sv
module led_scanner_chk #(
    parameter int unsigned NUM_LEDS = 8,
    localparam int unsigned POS_W   = (NUM_LEDS > 2) ? $clog2(NUM_LEDS) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_LEDS-1:0] led,
    input logic [POS_W-1:0]    head_pos,
    input logic                step
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_LEDS - 1);

    // R1: a cycle with reset sampled high leaves all LEDs dark
    p_reset_dark_r1: assert property (@(posedge clk) rst |=> (led == '0));

    // R2: the LED at the spot is driven in the cycle after
    p_head_lit_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> led[$past(head_pos)]);

    // R6: spot plus three-LED tail at most
    p_lit_count_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(led) <= 4);

    // R7: spot holds between step events
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(head_pos));

    // R7: spot moves exactly one position per step event
    p_one_pos_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> ((head_pos == $past(head_pos) + 1'b1) ||
                  (head_pos + 1'b1 == $past(head_pos))));

    // R8: turn at the top end
    p_turn_top_r8: assert property (@(posedge clk) disable iff (rst)
        (step && head_pos == POS_LAST) |=> (head_pos == POS_LAST - 1'b1));

    // R8: turn at the bottom end
    p_turn_bottom_r8: assert property (@(posedge clk) disable iff (rst)
        (step && head_pos == '0) |=> (head_pos == POS_W'(1)));

    // R8: spot never leaves the row
    p_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        head_pos <= POS_LAST);

endmodule

bind led_scanner led_scanner_chk #(
    .NUM_LEDS (NUM_LEDS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .led      (led),
    .head_pos (head_pos),
    .step     (step_pulse)
);

// File: tb/led_scanner_tb_top.sv
module led_scanner_tb_top;

    localparam int NL     = 5;
    localparam int STEP   = 200;
    localparam int WIN_LO = 50;
    localparam int WIN_N  = 100;
    localparam int LIMIT  = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] led;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int exp_q[$];
    int ref_pos;
    bit ref_up;

    always #10 clk = ~clk;   // 50 MHz

    led_scanner #(
        .NUM_LEDS   (NL),
        .STEP_TICKS (STEP)
    ) dut_i (
        .clk (clk),
        .rst (rst),
        .led (led)
    );

    function automatic int gap_duty(input int gap);
        case (gap)
            0: return 100;
            1: return 50;
            2: return 20;
            3: return 10;
            default: return 0;
        endcase
    endfunction

    function automatic string duty_tag(input int d);
        case (d)
            100: return "R2";
            50:  return "R3";
            20:  return "R4";
            10:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic ref_reset();
        ref_pos = 0;
        ref_up  = 1'b1;
    endtask

    // driver: push one entry per LED, then the spot index, for each step
    task automatic push_expected(input int nsteps);
        for (int s = 0; s < nsteps; s++) begin
            for (int i = 0; i < NL; i++) begin
                int gap;
                gap = -1;
                if (ref_up && i <= ref_pos) gap = ref_pos - i;
                if (!ref_up && i >= ref_pos) gap = i - ref_pos;
                exp_q.push_back(gap_duty(gap));
            end
            exp_q.push_back(ref_pos);
            if (ref_up) begin
                if (ref_pos == NL - 1) begin ref_pos--; ref_up = 1'b0; end
                else ref_pos++;
            end else begin
                if (ref_pos == 0) begin ref_pos++; ref_up = 1'b1; end
                else ref_pos--;
            end
        end
    endtask

    // monitor: count on-cycles in a 100-cycle window of each step
    task automatic check_steps(input int nsteps);
        for (int s = 0; s < nsteps; s++) begin
            int cnt[NL];
            int head_seen;
            int exp_head;
            int exp_duty;
            for (int i = 0; i < NL; i++) cnt[i] = 0;
            for (int c = 1; c <= STEP; c++) begin
                @(negedge clk);
                if (c >= WIN_LO && c < WIN_LO + WIN_N) begin
                    for (int i = 0; i < NL; i++) if (led[i]) cnt[i]++;
                end
            end
            head_seen = -1;
            for (int i = 0; i < NL; i++) begin
                exp_duty = exp_q.pop_front();
                total++;
                if (cnt[i] != exp_duty) begin
                    bad++;
                    $display("FAIL %s step %0d led %0d: duty actual=%0d expected=%0d",
                             duty_tag(exp_duty), s, i, cnt[i], exp_duty);
                end
                if (cnt[i] == 100) head_seen = i;
            end
            exp_head = exp_q.pop_front();
            total++;
            if (head_seen != exp_head) begin
                bad++;
                $display("FAIL R7/R8 step %0d: spot actual=%0d expected=%0d",
                         s, head_seen, exp_head);
            end
        end
    endtask

    task automatic check_dark(input string what);
        total++;
        if (led != '0) begin
            bad++;
            $display("FAIL R1 %s: led actual=%b expected=%b", what, led, {NL{1'b0}});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_dark("during reset");
        ref_reset();
        push_expected(20);
        rst = 1'b0;                 // released at a negedge
        check_steps(20);            // R7 R8 sweep with several turns

        // reset in mid-sweep, then restart from LED 0 moving up (R1)
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_dark("mid-run reset");
        ref_reset();
        push_expected(6);
        rst = 1'b0;
        check_steps(6);
        finish_run();
    end

    initial begin
        for (int k = 0; k < LIMIT; k++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: cycles actual=%0d expected below %0d", LIMIT, LIMIT);
        finish_run();
    end

endmodule